// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. A single test clock and one mode line walk a sixteen-state controller. From that state walk the block loads a four-bit instruction, and it moves data through whichever data register that instruction selects. Every transfer is full-duplex: new bits come in on the serial input while the previous contents leave on the serial output.

The block itself holds a one-bit bypass stage and a fixed identification register. The boundary chain lives outside the block. The block reaches it through a serial pair and three strobes, and those strobes are active only while the boundary instruction is held. For other external registers, the block exports the raw capture, shift and update strobes of both scan paths. The serial output is driven from the falling clock edge, and its enable output is high only in the two shift states.

Top module: `tap_controller`

## Requirements
- R1: Holding `tap_rst_n` low across a rising `tck` edge, or five consecutive rising edges with `tms` high from any state, puts the controller in its reset state. Entry into that state loads the active instruction with the identify code 4'b0010.
- R2: Every state has exactly two successors, and `tms` sampled on the rising edge chooses between them. The pause states of a data scan can be entered and left again without losing or repeating any shifted bit.
- R3: During an instruction scan, the shift stage holds 4'b0001 on entry to the shift state, so the first four bits out, least significant first, are 1, 0, 0, 0.
- R4: `ir_value` keeps its old value through capture, shift and exit of an instruction scan. It takes the shifted value on the rising edge that enters the update-instruction state.
- R5: Instruction 4'b0000 selects the external boundary chain and 4'b0010 selects the identification register. The value 4'b1111 and every other code select the bypass stage.
- R6: The bypass stage captures 0 and then delays `tdi` by exactly one shift cycle on its way to `tdo`.
- R7: The identification register captures `ID_VALUE` and shifts it out least significant bit first, followed by the bits entered on `tdi`.
- R8: `bnd_sel` is high only while instruction 4'b0000 is held. `bnd_capture`, `bnd_shift` and `bnd_update` never pulse under any other instruction. In boundary mode `tdo` follows `bnd_so` and `bnd_si` carries `tdi`.
- R9: `tdo_oe` is high only while the controller is in shift-DR or shift-IR. `tdo` changes only on a falling edge of `tck`.
- R10: Each of `dr_capture`, `dr_shift`, `dr_update`, `ir_capture`, `ir_shift` and `ir_update` is high exactly while the controller is in its state, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst_n | input | 1 | Synchronous active-low port reset |
| tms | input | 1 | Mode select that steers the state walk |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, driven on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo, high in shift states |
| ir_value | output | 4 | Active instruction |
| dr_capture | output | 1 | Controller is in capture-DR |
| dr_shift | output | 1 | Controller is in shift-DR |
| dr_update | output | 1 | Controller is in update-DR |
| ir_capture | output | 1 | Controller is in capture-IR |
| ir_shift | output | 1 | Controller is in shift-IR |
| ir_update | output | 1 | Controller is in update-IR |
| bnd_sel | output | 1 | Boundary instruction is active |
| bnd_capture | output | 1 | Capture strobe for the boundary chain |
| bnd_shift | output | 1 | Shift strobe for the boundary chain |
| bnd_update | output | 1 | Update strobe for the boundary chain |
| bnd_si | output | 1 | Serial input into the boundary chain |
| bnd_so | input | 1 | Serial output from the boundary chain |

## Verification
The bench loads all sixteen instruction codes. After each load it runs a 40-bit data scan and compares the returned stream with the bypass, identification or boundary image the code should select. A decoder that missed the default-to-bypass rule would return identification or boundary bits for an undefined code. An instruction that took effect before update would show up as an early change of `ir_value` in the exit state. Several scans detour through the pause states; a design that shifted on the detour would return a stream skewed by one bit. The bench also counts `tms` ones out of shift-DR, and a reset that fired after four ones, or never fired, shows up in `ir_value`.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_BOUNDARY = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDENT    = 4'b0010;
    localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAUSE_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAUSE_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_BOUNDARY
    } dr_path_e;

    typedef struct packed {
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
    } tap_strobe_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   n = m ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   n = m ? ST_EX1_DR   : ST_SH_DR;
            ST_SH_DR:    n = m ? ST_EX1_DR   : ST_SH_DR;
            ST_EX1_DR:   n = m ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: n = m ? ST_EX2_DR   : ST_PAUSE_DR;
            ST_EX2_DR:   n = m ? ST_UPD_DR   : ST_SH_DR;
            ST_UPD_DR:   n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   n = m ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   n = m ? ST_EX1_IR   : ST_SH_IR;
            ST_SH_IR:    n = m ? ST_EX1_IR   : ST_SH_IR;
            ST_EX1_IR:   n = m ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: n = m ? ST_EX2_IR   : ST_PAUSE_IR;
            ST_EX2_IR:   n = m ? ST_UPD_IR   : ST_SH_IR;
            ST_UPD_IR:   n = m ? ST_SEL_DR   : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic dr_path_e decode_path(input logic [IR_W-1:0] op);
        dr_path_e p;
        if (op == OP_BOUNDARY)
            p = PATH_BOUNDARY;
        else if (op == OP_IDENT)
            p = PATH_IDENT;
        else
            p = PATH_BYPASS;
        return p;
    endfunction

    function automatic tap_strobe_t state_strobes(input tap_state_e s);
        tap_strobe_t t;
        t.cap_dr = (s == ST_CAP_DR);
        t.sh_dr  = (s == ST_SH_DR);
        t.upd_dr = (s == ST_UPD_DR);
        t.cap_ir = (s == ST_CAP_IR);
        t.sh_ir  = (s == ST_SH_IR);
        t.upd_ir = (s == ST_UPD_IR);
        return t;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e state_nx
);

    always_comb state_nx = tap_next(state, tms);

    always_ff @(posedge tck) begin
        if (!rst_n)
            state <= ST_RESET;
        else
            state <= state_nx;
    end

    // Independent run length of tms ones, used only by the checks below.
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (!rst_n)
            ones_run <= 3'd0;
        else if (!tms)
            ones_run <= 3'd0;
        else if (ones_run != 3'd7)
            ones_run <= ones_run + 3'd1;
    end

    // R1: the port reset lands in the reset state
    a_r1_pin_reset: assert property (@(posedge tck)
        !rst_n |=> state == ST_RESET);

    // R1: the fifth consecutive tms one always lands in the reset state
    a_r1_five_ones: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_run >= 3'd4 && tms) |=> state == ST_RESET);

    // R2: shift-DR is left only with tms high
    a_r2_shift_leave: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_SH_DR && !tms) |=> state == ST_SH_DR);

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  tap_state_e      state_nx,
    input  logic            tdi,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_active
);

    logic [IR_W-1:0] ir_stage;

    always_ff @(posedge tck) begin
        if (!rst_n)
            ir_stage <= IR_CAPTURE;
        else if (state == ST_CAP_IR)
            ir_stage <= IR_CAPTURE;
        else if (state == ST_SH_IR)
            ir_stage <= {tdi, ir_stage[IR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (!rst_n || state_nx == ST_RESET)
            ir_active <= OP_IDENT;
        else if (state_nx == ST_UPD_IR)
            ir_active <= ir_stage;
    end

    assign ir_so = ir_stage[0];

    // R4: the active instruction moves only on entry to update-IR or reset
    a_r4_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (state_nx != ST_UPD_IR && state_nx != ST_RESET) |=> $stable(ir_active));

    // R3: the first bit presented in shift-IR is a one
    a_r3_first_bit: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> ir_so);

endmodule

// File: rtl/tap_dr_bank.sv
`timescale 1ns/1ps
module tap_dr_bank
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1E5C_A0B3
) (
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       tdi,
    output logic       byp_so,
    output logic       id_so
);

    logic cap_byp, sh_byp, cap_id, sh_id;

    always_comb begin
        cap_byp = (state == ST_CAP_DR) && (path == PATH_BYPASS);
        sh_byp  = (state == ST_SH_DR)  && (path == PATH_BYPASS);
        cap_id  = (state == ST_CAP_DR) && (path == PATH_IDENT);
        sh_id   = (state == ST_SH_DR)  && (path == PATH_IDENT);
    end

    always_ff @(posedge tck) begin
        if (!rst_n || cap_byp)
            byp_so <= 1'b0;
        else if (sh_byp)
            byp_so <= tdi;
    end

    logic [ID_W-1:0] id_q;

    for (genvar b = 0; b < ID_W; b++) begin : g_id
        logic feed;
        if (b == ID_W - 1) begin : g_top
            assign feed = tdi;
        end else begin : g_mid
            assign feed = id_q[b+1];
        end
        always_ff @(posedge tck) begin
            if (!rst_n)
                id_q[b] <= 1'b0;
            else if (cap_id)
                id_q[b] <= ID_VALUE[b];
            else if (sh_id)
                id_q[b] <= feed;
        end
    end

    assign id_so = id_q[0];

    // R6: the bypass stage delays tdi by one shift cycle
    a_r6_bypass_delay: assert property (@(posedge tck) disable iff (!rst_n)
        sh_byp |=> byp_so == $past(tdi));

    // R7: the identification register presents its low bit after capture
    a_r7_id_first: assert property (@(posedge tck) disable iff (!rst_n)
        cap_id |=> id_so == ID_VALUE[0]);

endmodule

// File: rtl/tap_controller.sv
`timescale 1ns/1ps
module tap_controller
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1E5C_A0B3
) (
    input  logic            tck,
    input  logic            tap_rst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [IR_W-1:0] ir_value,
    output logic            dr_capture,
    output logic            dr_shift,
    output logic            dr_update,
    output logic            ir_capture,
    output logic            ir_shift,
    output logic            ir_update,
    output logic            bnd_sel,
    output logic            bnd_capture,
    output logic            bnd_shift,
    output logic            bnd_update,
    output logic            bnd_si,
    input  logic            bnd_so
);

    tap_state_e  state, state_nx;
    dr_path_e    path;
    tap_strobe_t stb;
    logic        ir_so, byp_so, id_so, sel_bit, in_shift;

    tap_fsm u_fsm (
        .tck      (tck),
        .rst_n    (tap_rst_n),
        .tms      (tms),
        .state    (state),
        .state_nx (state_nx)
    );

    tap_ir u_ir (
        .tck       (tck),
        .rst_n     (tap_rst_n),
        .state     (state),
        .state_nx  (state_nx),
        .tdi       (tdi),
        .ir_so     (ir_so),
        .ir_active (ir_value)
    );

    always_comb path = decode_path(ir_value);

    tap_dr_bank #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .rst_n  (tap_rst_n),
        .state  (state),
        .path   (path),
        .tdi    (tdi),
        .byp_so (byp_so),
        .id_so  (id_so)
    );

    always_comb stb = state_strobes(state);

    assign dr_capture = stb.cap_dr;
    assign dr_shift   = stb.sh_dr;
    assign dr_update  = stb.upd_dr;
    assign ir_capture = stb.cap_ir;
    assign ir_shift   = stb.sh_ir;
    assign ir_update  = stb.upd_ir;

    assign bnd_sel     = (path == PATH_BOUNDARY);
    assign bnd_capture = bnd_sel && stb.cap_dr;
    assign bnd_shift   = bnd_sel && stb.sh_dr;
    assign bnd_update  = bnd_sel && stb.upd_dr;
    assign bnd_si      = tdi;

    always_comb begin
        in_shift = stb.sh_dr || stb.sh_ir;
        if (stb.sh_ir) begin
            sel_bit = ir_so;
        end else begin
            case (path)
                PATH_IDENT:    sel_bit = id_so;
                PATH_BOUNDARY: sel_bit = bnd_so;
                default:       sel_bit = byp_so;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (!tap_rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= sel_bit;
            tdo_oe <= in_shift;
        end
    end

    // R9: the serial output is enabled only inside a shift state
    a_r9_oe_shift: assert property (@(posedge tck) disable iff (!tap_rst_n)
        tdo_oe |-> (dr_shift || ir_shift));

    // R10: the state strobes never overlap
    a_r10_onehot: assert property (@(posedge tck) disable iff (!tap_rst_n)
        $onehot0({dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update}));

    // R8: boundary strobes follow the DR strobes only under the boundary code
    a_r8_bnd_gate: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (bnd_capture || bnd_shift || bnd_update) |-> (ir_value == OP_BOUNDARY));

    // R5: boundary selection implies the boundary code
    a_r5_sel_code: assert property (@(posedge tck) disable iff (!tap_rst_n)
        bnd_sel |-> ir_value == OP_BOUNDARY);

endmodule

// File: tb/tap_controller_tb_top.sv
`timescale 1ns/1ps
module tap_controller_tb_top;

    localparam logic [31:0] IDV = 32'h1E5C_A0B3;
    localparam logic [7:0]  BND_CAP = 8'hA5;

    logic tck = 1'b0;
    always #5 tck = ~tck;

    logic       tap_rst_n, tms, tdi;
    logic       tdo, tdo_oe;
    logic [3:0] ir_value;
    logic       dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update;
    logic       bnd_sel, bnd_capture, bnd_shift, bnd_update, bnd_si, bnd_so;

    tap_controller #(.ID_W(32), .ID_VALUE(IDV)) dut_i (
        .tck(tck), .tap_rst_n(tap_rst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .ir_value(ir_value),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .bnd_sel(bnd_sel), .bnd_capture(bnd_capture), .bnd_shift(bnd_shift),
        .bnd_update(bnd_update), .bnd_si(bnd_si), .bnd_so(bnd_so)
    );

    // External boundary chain model: strobes sampled at the falling edge.
    logic [7:0] bmod = 8'h00, bupd = 8'h00;
    logic cq = 1'b0, sq = 1'b0, uq = 1'b0, leak = 1'b0;
    assign bnd_so = bmod[0];

    always @(negedge tck) begin
        cq <= bnd_capture;
        sq <= bnd_shift;
        uq <= bnd_update;
        if ((bnd_capture || bnd_shift || bnd_update) && ir_value != 4'b0000)
            leak <= 1'b1;
    end

    always @(posedge tck) begin
        if (cq)
            bmod <= BND_CAP;
        else if (sq)
            bmod <= {bnd_si, bmod[7:1]};
        if (uq)
            bupd <= bmod;
    end

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] strobes();
        return {dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update};
    endfunction

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    function automatic logic [63:0] expect_dr(input logic [3:0] op, input int n,
                                              input logic [63:0] din);
        logic [63:0] e = '0;
        for (int i = 0; i < n; i++) begin
            if (op == 4'b0000)
                e[i] = (i < 8) ? BND_CAP[i] : din[i-8];
            else if (op == 4'b0010)
                e[i] = (i < 32) ? IDV[i] : din[i-32];
            else
                e[i] = (i == 0) ? 1'b0 : din[i-1];
        end
        return e;
    endfunction

    task automatic load_ir(input logic [3:0] op);
        logic [3:0] cap;
        logic [3:0] old;
        old = ir_value;
        step(1, 0);
        step(1, 0);
        step(0, 0);
        chk(strobes() == 6'b000100, "R10", "capture-IR strobe", strobes(), 6'b000100);
        step(0, 0);
        chk(tdo_oe == 1'b1, "R9", "oe in shift-IR", tdo_oe, 1);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            step(i == 3, op[i]);
            if (i < 3)
                chk(ir_value == old, "R4", "instruction moved during shift", ir_value, old);
        end
        chk(ir_value == old, "R4", "instruction moved in exit1", ir_value, old);
        chk(tdo_oe == 1'b0, "R9", "oe after shift-IR", tdo_oe, 0);
        chk(cap == 4'b0001, "R3", "captured IR bits", cap, 4'b0001);
        step(1, 0);
        chk(ir_value == op, "R4", "instruction on update", ir_value, op);
        chk(strobes() == 6'b000001, "R10", "update-IR strobe", strobes(), 6'b000001);
        step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, input int pause_at,
                           output logic [63:0] dout);
        logic held;
        dout = '0;
        step(1, 0);
        step(0, 0);
        chk(strobes() == 6'b100000, "R10", "capture-DR strobe", strobes(), 6'b100000);
        step(0, 0);
        chk(strobes() == 6'b010000, "R10", "shift-DR strobe", strobes(), 6'b010000);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (i == n - 1) begin
                step(1, din[i]);
            end else if (i == pause_at) begin
                step(1, din[i]);
                step(0, 0);
                chk(strobes() == 6'b000000 && tdo_oe == 1'b0, "R2", "pause-DR quiet",
                    {strobes(), tdo_oe}, 0);
                step(1, 0);
                step(0, 0);
            end else if (i == 1) begin
                held = tdo;
                tms = 0;
                tdi = din[i];
                @(posedge tck);
                #1;
                chk(tdo == held, "R9", "tdo moved at rising edge", tdo, held);
                @(negedge tck);
                #1;
            end else begin
                step(0, din[i]);
            end
        end
        step(1, 0);
        chk(strobes() == 6'b001000, "R10", "update-DR strobe", strobes(), 6'b001000);
        step(0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] dout, din;
        tap_rst_n = 1'b0;
        tms = 1'b0;
        tdi = 1'b0;
        @(negedge tck);
        #1;
        step(0, 0);
        step(0, 0);
        chk(ir_value == 4'b0010, "R1", "instruction after port reset", ir_value, 4'b0010);
        chk(tdo_oe == 1'b0, "R9", "oe in reset", tdo_oe, 0);
        chk(strobes() == 6'b000000, "R10", "strobes in reset", strobes(), 0);
        tap_rst_n = 1'b1;
        step(0, 0);

        din = 64'h0000_00F0_3C96_5AA5;
        scan_dr(40, din, -1, dout);
        chk(dout[39:0] == expect_dr(4'b0010, 40, din)[39:0], "R7", "ident after reset",
            dout[39:0], expect_dr(4'b0010, 40, din)[39:0]);

        for (int op = 0; op < 16; op++) begin
            logic [3:0] code = op[3:0];
            din = 64'h0000_00C3_A59E_176B ^ (64'(op) * 64'h0000_0011_0F0F_2481);
            load_ir(code);
            chk(bnd_sel == (code == 4'b0000), "R8", "boundary select", bnd_sel, code == 4'b0000);
            scan_dr(40, din, (op % 3 == 0) ? 13 : -1, dout);
            chk(dout[39:0] == expect_dr(code, 40, din)[39:0], "R5", "data path for opcode",
                dout[39:0], expect_dr(code, 40, din)[39:0]);
            if (code == 4'b1111)
                chk(dout[0] == 1'b0, "R6", "bypass captures zero", dout[0], 0);
            if (code == 4'b0000)
                chk(bupd == din[39:32], "R8", "boundary update value", bupd, din[39:32]);
        end
        chk(leak == 1'b0, "R8", "boundary strobe under other code", leak, 0);

        // R1: five tms ones out of shift-DR
        load_ir(4'b1111);
        step(1, 0);
        step(0, 0);
        step(0, 0);
        for (int k = 0; k < 4; k++) step(1, 0);
        chk(ir_value == 4'b1111, "R1", "reset after only four ones", ir_value, 4'b1111);
        step(1, 0);
        chk(ir_value == 4'b0010, "R1", "fifth tms one resets", ir_value, 4'b0010);
        chk(strobes() == 6'b000000, "R2", "reset state strobes", strobes(), 0);
        step(0, 0);

        // R1: port reset in the middle of a walk
        load_ir(4'b0000);
        step(1, 0);
        tap_rst_n = 1'b0;
        step(0, 0);
        chk(ir_value == 4'b0010, "R1", "port reset mid-walk", ir_value, 4'b0010);
        tap_rst_n = 1'b1;
        step(0, 0);
        din = 64'h0000_0055_1234_8765;
        scan_dr(40, din, 20, dout);
        chk(dout[39:0] == expect_dr(4'b0010, 40, din)[39:0], "R2", "ident with pause",
            dout[39:0], expect_dr(4'b0010, 40, din)[39:0]);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule